// File: doc/BRIEF.md
# Serialized Register Mailbox Responder

This block is the device side of a host-to-device mailbox reached over a simple 32-bit register bus. Four word registers are exposed: control, status, a write-data port and a read-data port. The host streams a framed request into the write-data port one dword at a time, and the block keeps it in an internal buffer. The host then sets the go bit. The block checks the framing. A well-formed request is handed to a stub processing stage, which walks the payload and prepares a four-dword response. When the response is available, the block raises ready.

The host reads the response through the read-data port one dword at a time. A read returns the current dword. A write of any value to the same port acknowledges that dword and moves to the next one. A request with bad framing sets the error bit and produces no response. Abort returns the block to idle at once. The stub generator stands in for real firmware. It treats a request as good when the 32-bit wrapping sum of its payload is zero.

Top module: `mbx_responder`

## Requirements
- R1: After reset, status reads 0 and the read-data port reads 0.
- R2: `bus_word` selects the register: 0 is control, 1 is status, 2 is write data, 3 is read data. In status, bit 31 is ready and bit 2 is error, and every other bit reads 0.
- R3: A request is an ordered list of dwords: header `{8'h00, OBJ_TYPE, VENDOR_ID}`, total length in dwords (payload + 4), command `CMD_LOAD` (3), a zero word, then the payload. Writing control bit 31 (go) with correct framing starts processing, and ready is set when processing completes.
- R4: At go, the block sets error and never sets ready if any of these holds: the header differs, the length differs from the dword count received, the command is not 3, the fourth word is not zero, or fewer than 4 dwords were received.
- R5: A request that carries more than `PAYLOAD_MAX` payload dwords sets error at go, even when its length word matches.
- R6: While ready is set, the read-data port returns the response words in this order: header, 4, next offset, flag. A write to the read-data port advances to the next word. After four acknowledges the port reads 0, and further acknowledges have no effect.
- R7: If the 32-bit sum of the payload dwords is zero, the next offset is 4 × payload dwords and the flag is 1 (bit 0, success). Otherwise the offset is 0 and the flag is 4 (bit 2, error).
- R8: Writing control bit 0 (abort) clears ready, error, the request write position and the response read position in one cycle. An abort during processing stops it, so ready is not set.
- R9: A go write clears ready and restarts the response position. When abort and go are written together, abort wins and neither error nor ready is set.
- R10: While processing is in progress, writes to the write-data port and go writes are ignored.
- R11: Reads of the control and write-data registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_word | input | 2 | Register word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by `bus_word` (combinational) |

## Verification
The assertions assume that `bus_word` and `bus_wdata` are known whenever `bus_wr` is high, and that each write is a one-cycle pulse. They also assume the read path is sampled only after `bus_word` has settled. The bench drives every bus input at the falling edge, holds `bus_wr` high for exactly one cycle, and samples `bus_rdata` shortly after it changes the address. Because of this, the status and response values it compares were produced by the previous rising edge alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_WDATA = 2'd2,
    REG_RDATA = 2'd3
  } mbx_reg_e;

  typedef enum logic {
    PROC_IDLE = 1'b0,
    PROC_WALK = 1'b1
  } proc_state_e;

  localparam int unsigned CTRL_ABORT_BIT = 0;
  localparam int unsigned CTRL_GO_BIT    = 31;
  localparam int unsigned STAT_ERR_BIT   = 2;
  localparam int unsigned STAT_RDY_BIT   = 31;
  localparam int unsigned FRAME_WORDS    = 4;
  localparam int unsigned RSP_WORDS      = 4;
  localparam logic [31:0] FLAG_SUCCESS   = 32'h0000_0001;
  localparam logic [31:0] FLAG_FAILED    = 32'h0000_0004;

endpackage

// File: rtl/mbx_reqbuf.sv
module mbx_reqbuf
  import mbx_pkg::*;
#(
  parameter int unsigned PAYLOAD_MAX = 8,
  parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
  parameter logic [7:0]  OBJ_TYPE    = 8'h0B,
  parameter logic [31:0] CMD_LOAD    = 32'h3,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [31:0]      push_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             frame_ok,
  output logic [CNT_W-1:0] pay_cnt,
  output logic [31:0]      rd_data
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PAYLOAD_MAX + FRAME_WORDS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_WORDS);
  localparam logic [31:0]      HDR_WORD = {8'h00, OBJ_TYPE, VENDOR_ID};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [31:0]      frm_q [FRAME_WORDS];
  logic [31:0]      pay_q [PAYLOAD_MAX];
  logic [CNT_W-1:0] pay_wr_pos;

  assign pay_wr_pos = cnt_q - CNT_HDR;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clear) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (push) begin
      if (cnt_q == CNT_MAX) ovf_d = 1'b1;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar f = 0; f < FRAME_WORDS; f++) begin : g_frm
    logic frm_en;
    assign frm_en = push && !clear && (cnt_q == CNT_W'(f));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      frm_q[f] <= '0;
      else if (frm_en) frm_q[f] <= push_data;
    end
  end

  for (genvar p = 0; p < PAYLOAD_MAX; p++) begin : g_pay
    logic pay_en;
    assign pay_en = push && !clear && (cnt_q >= CNT_HDR) && (pay_wr_pos == CNT_W'(p));
    always_ff @(posedge clk) begin
      if (pay_en) pay_q[p] <= push_data;
    end
  end

  always_comb begin
    frame_ok = !ovf_q && (cnt_q >= CNT_HDR)
            && (frm_q[0] == HDR_WORD)
            && (frm_q[1] == 32'(cnt_q))
            && (frm_q[2] == CMD_LOAD)
            && (frm_q[3] == 32'h0);
    pay_cnt = (cnt_q >= CNT_HDR) ? pay_wr_pos : '0;
    rd_data = (32'(rd_idx) < PAYLOAD_MAX) ? pay_q[rd_idx] : 32'h0;
  end

endmodule

// File: rtl/mbx_proc.sv
module mbx_proc
  import mbx_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] pay_cnt,
  input  logic [31:0]      pay_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rsp_offset,
  output logic [31:0]      rsp_flag
);

  proc_state_e      st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic [31:0]      sum_q, sum_d;
  logic [31:0]      off_q, off_d;
  logic [31:0]      flag_q, flag_d;
  logic             finish;

  assign finish = (st_q == PROC_WALK) && (idx_q == n_q) && !abort;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    n_d    = n_q;
    sum_d  = sum_q;
    off_d  = off_q;
    flag_d = flag_q;
    if (st_q == PROC_IDLE) begin
      if (start && !abort) begin
        st_d  = PROC_WALK;
        idx_d = '0;
        n_d   = pay_cnt;
        sum_d = '0;
      end
    end else if (abort) begin
      st_d = PROC_IDLE;
    end else if (finish) begin
      st_d   = PROC_IDLE;
      off_d  = (sum_q == 32'h0) ? (32'(n_q) << 2) : 32'h0;
      flag_d = (sum_q == 32'h0) ? FLAG_SUCCESS : FLAG_FAILED;
    end else begin
      sum_d = sum_q + pay_data;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PROC_IDLE;
      idx_q  <= '0;
      n_q    <= '0;
      sum_q  <= '0;
      off_q  <= '0;
      flag_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      n_q    <= n_d;
      sum_q  <= sum_d;
      off_q  <= off_d;
      flag_q <= flag_d;
    end
  end

  assign rd_idx     = idx_q[IDX_W-1:0];
  assign busy       = (st_q == PROC_WALK);
  assign done       = finish;
  assign rsp_offset = off_q;
  assign rsp_flag   = flag_q;

endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int unsigned PAYLOAD_MAX = 8,
  parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
  parameter logic [7:0]  OBJ_TYPE    = 8'h0B,
  parameter logic [31:0] CMD_LOAD    = 32'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int unsigned IDX_W   = (PAYLOAD_MAX > 1) ? $clog2(PAYLOAD_MAX) : 1;
  localparam int unsigned CNT_W   = $clog2(PAYLOAD_MAX + FRAME_WORDS + 1);
  localparam int unsigned RPTR_W  = $clog2(RSP_WORDS + 1);
  localparam logic [RPTR_W-1:0] RPTR_END = RPTR_W'(RSP_WORDS);

  logic             wr_ctrl, do_abort, do_go, do_push, do_ack;
  logic             frame_ok, busy, done;
  logic [CNT_W-1:0] pay_cnt;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      pay_data, rsp_offset, rsp_flag, rsp_word, status;
  logic             ready_q, ready_d;
  logic             error_q, error_d;
  logic [RPTR_W-1:0] rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_word == REG_CTRL);
    do_abort = wr_ctrl && bus_wdata[CTRL_ABORT_BIT];
    do_go    = wr_ctrl && bus_wdata[CTRL_GO_BIT] && !do_abort && !busy;
    do_push  = bus_wr && (bus_word == REG_WDATA) && !busy;
    do_ack   = bus_wr && (bus_word == REG_RDATA) && ready_q && (rd_ptr_q != RPTR_END);
  end

  mbx_reqbuf #(
    .PAYLOAD_MAX(PAYLOAD_MAX), .VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE),
    .CMD_LOAD(CMD_LOAD), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_reqbuf (
    .clk(clk), .rst_n(rst_n), .clear(do_go || do_abort), .push(do_push),
    .push_data(bus_wdata), .rd_idx(rd_idx), .frame_ok(frame_ok),
    .pay_cnt(pay_cnt), .rd_data(pay_data)
  );

  mbx_proc #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_proc (
    .clk(clk), .rst_n(rst_n), .start(do_go && frame_ok), .abort(do_abort),
    .pay_cnt(pay_cnt), .pay_data(pay_data), .rd_idx(rd_idx), .busy(busy),
    .done(done), .rsp_offset(rsp_offset), .rsp_flag(rsp_flag)
  );

  always_comb begin
    ready_d  = ready_q;
    error_d  = error_q;
    rd_ptr_d = rd_ptr_q;
    if (do_abort) begin
      ready_d  = 1'b0;
      error_d  = 1'b0;
      rd_ptr_d = '0;
    end else if (do_go) begin
      ready_d  = 1'b0;
      error_d  = !frame_ok;
      rd_ptr_d = '0;
    end else begin
      if (done)   ready_d  = 1'b1;
      if (do_ack) rd_ptr_d = rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      error_q  <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      ready_q  <= ready_d;
      error_q  <= error_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_comb begin
    case (rd_ptr_q)
      RPTR_W'(0): rsp_word = {8'h00, OBJ_TYPE, VENDOR_ID};
      RPTR_W'(1): rsp_word = 32'(RSP_WORDS);
      RPTR_W'(2): rsp_word = rsp_offset;
      RPTR_W'(3): rsp_word = rsp_flag;
      default:    rsp_word = 32'h0;
    endcase
    status               = '0;
    status[STAT_RDY_BIT] = ready_q;
    status[STAT_ERR_BIT] = error_q;
    case (bus_word)
      REG_STAT:  bus_rdata = status;
      REG_RDATA: bus_rdata = ready_q ? rsp_word : 32'h0;
      default:   bus_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/mbx_responder_chk.sv
module mbx_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_word,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        ready,
  input logic        error,
  input logic        busy,
  input logic [2:0]  rd_ptr
);

  logic abort_wr, go_wr;
  assign abort_wr = bus_wr && (bus_word == 2'd0) && bus_wdata[0];
  assign go_wr    = bus_wr && (bus_word == 2'd0) && bus_wdata[31] && !bus_wdata[0];

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!ready && !error && !busy && rd_ptr == 3'd0));

  p_go_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> !ready);

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, error, busy}));

  p_rdptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= 3'd4);

  p_idle_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == 2'd3 && !ready) |-> bus_rdata == 32'h0);

  p_busy_ends_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort_wr) |=> (busy || ready));

  p_status_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == 2'd1) |-> ((bus_rdata & 32'h7FFF_FFFB) == 32'h0));

endmodule

bind mbx_responder mbx_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready_q),
  .error(error_q), .busy(busy), .rd_ptr(rd_ptr_q)
);

// File: tb/mbx_responder_test.sv
`timescale 1ns/1ps
module mbx_responder_test;

  localparam int          PMAX = 8;
  localparam logic [31:0] HDR  = 32'h000B_1D5A;
  localparam logic [31:0] RDY  = 32'h8000_0000;
  localparam logic [31:0] ERR  = 32'h0000_0004;

  logic        clk, rst_n, bus_wr;
  logic [1:0]  bus_word;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pl [16];
  int checks = 0, errors = 0;
  bit finished = 0;

  mbx_responder uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic send(input logic [31:0] h, len, cmd, rsv, input int n);
    wr(2, h); wr(2, len); wr(2, cmd); wr(2, rsv);
    for (int i = 0; i < n; i++) wr(2, pl[i]);
  endtask

  task automatic wait_ready(output bit got);
    logic [31:0] s;
    got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rd(1, s);
      if (s[31]) begin got = 1; break; end
    end
  endtask

  task automatic read_rsp(input string tag, input logic [31:0] off, flag);
    logic [31:0] v;
    logic [31:0] exp [4];
    exp[0] = HDR; exp[1] = 4; exp[2] = off; exp[3] = flag;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rd(3, v);
      chk(tag, v, exp[i]);
      wr(3, 32'h0);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    rd(1, v); chk("R1 status after reset", v, 0);
    rd(3, v); chk("R1 rdata after reset", v, 0);
    rd(0, v); chk("R11 control reads zero", v, 0);
    rd(2, v); chk("R11 wdata reads zero", v, 0);
  endtask

  task automatic t_good_load;
    bit got; logic [31:0] v;
    pl[0] = 5; pl[1] = 7; pl[2] = 32'hFFFF_FFF4;
    send(HDR, 7, 3, 0, 3); wr(0, RDY);
    wait_ready(got);
    chk("R3 ready after good request", 32'(got), 1);
    rd(1, v); chk("R2 status ready only", v, RDY);
    read_rsp("R6 R7 response sum zero", 12, 1);
    @(negedge clk); rd(3, v); chk("R6 reads zero after four acks", v, 0);
    wr(3, 0); @(negedge clk); rd(3, v); chk("R6 extra ack no effect", v, 0);
    rd(1, v); chk("R6 still ready after drain", v, RDY);
  endtask

  task automatic t_bad_sum;
    bit got;
    pl[0] = 1; pl[1] = 2;
    send(HDR, 6, 3, 0, 2); wr(0, RDY);
    wait_ready(got); chk("R7 ready on nonzero sum", 32'(got), 1);
    read_rsp("R7 response nonzero sum", 0, 4);
    send(HDR, 4, 3, 0, 0); wr(0, RDY);
    wait_ready(got); chk("R7 ready empty payload", 32'(got), 1);
    read_rsp("R7 response empty payload", 0, 1);
  endtask

  task automatic bad_case(input string tag, input logic [31:0] h, len, cmd, rsv, input int n);
    logic [31:0] v;
    send(h, len, cmd, rsv, n); wr(0, RDY);
    rd(1, v); chk(tag, v, ERR);
    repeat (15) @(negedge clk);
    rd(1, v); chk(tag, v, ERR);
    wr(0, 1);
  endtask

  task automatic t_framing;
    logic [31:0] v;
    pl[0] = 0;
    bad_case("R4 wrong object type", 32'h000C_1D5A, 5, 3, 0, 1);
    bad_case("R4 wrong vendor", 32'h000B_1D5B, 5, 3, 0, 1);
    bad_case("R4 nonzero top byte", 32'h010B_1D5A, 5, 3, 0, 1);
    bad_case("R4 length mismatch", HDR, 6, 3, 0, 1);
    bad_case("R4 wrong command", HDR, 5, 2, 0, 1);
    bad_case("R4 nonzero fourth word", HDR, 5, 3, 1, 1);
    wr(2, HDR); wr(2, 2); wr(0, RDY);
    rd(1, v); chk("R4 short request", v, ERR);
    wr(0, 1);
    for (int i = 0; i < PMAX + 1; i++) pl[i] = 0;
    bad_case("R5 payload over buffer", HDR, PMAX + 5, 3, 0, PMAX + 1);
  endtask

  task automatic t_abort;
    bit got; logic [31:0] v;
    wr(2, HDR); wr(2, 5); wr(0, 1);
    pl[0] = 0;
    send(HDR, 5, 3, 0, 1); wr(0, RDY);
    wait_ready(got); chk("R8 restart after mid-stream abort", 32'(got), 1);
    @(negedge clk); rd(3, v); chk("R8 header before abort", v, HDR);
    wr(3, 0); wr(0, 1);
    rd(1, v); chk("R8 status cleared by abort", v, 0);
    rd(3, v); chk("R8 rdata zero after abort", v, 0);
    for (int i = 0; i < 7; i++) pl[i] = i + 1;
    pl[7] = 32'hFFFF_FFE4;
    send(HDR, 12, 3, 0, 8); wr(0, RDY); wr(0, 1);
    repeat (20) @(negedge clk);
    rd(1, v); chk("R8 abort during processing", v, 0);
  endtask

  task automatic t_go_rules;
    bit got; logic [31:0] v;
    pl[0] = 0;
    send(HDR, 5, 3, 0, 1); wr(0, RDY);
    wait_ready(got);
    wr(0, RDY);
    rd(1, v); chk("R9 go clears ready", v, ERR);
    wr(0, 1);
    send(HDR, 5, 3, 0, 1); wr(0, 32'h8000_0001);
    repeat (10) @(negedge clk);
    rd(1, v); chk("R9 abort wins over go", v, 0);
  endtask

  task automatic t_busy_ignore;
    bit got; logic [31:0] v;
    for (int i = 0; i < 7; i++) pl[i] = i + 1;
    pl[7] = 32'hFFFF_FFE4;
    send(HDR, 12, 3, 0, 8); wr(0, RDY);
    wr(2, 32'hDEAD_0001); wr(2, 32'hDEAD_0002); wr(2, 32'hDEAD_0003);
    wr(0, RDY);
    wait_ready(got); chk("R10 ready despite busy writes", 32'(got), 1);
    rd(1, v); chk("R10 no error from ignored go", v, RDY);
    read_rsp("R10 response unaffected", 32, 1);
    pl[0] = 0;
    send(HDR, 5, 3, 0, 1); wr(0, RDY);
    wait_ready(got); chk("R10 next request framed cleanly", 32'(got), 1);
    read_rsp("R10 next response", 4, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_word = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_good_load();
    t_bad_sum();
    t_framing();
    t_abort();
    t_go_rules();
    t_busy_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule